// File: doc/BRIEF.md
# DDR SDRAM Refresh and Self-Refresh Sequencer

This block keeps a DDR SDRAM refreshed on behalf of the main command scheduler. A free-running interval counter adds one owed refresh each time the average refresh period elapses. While refreshes are owed, the block raises a bus request. When the scheduler grants the bus, the block closes every bank with one precharge-all command. It then issues one AUTO REFRESH per owed refresh, spaced by the refresh cycle time, and holds a busy flag so that the scheduler sends nothing else meanwhile. When the backlog reaches its limit, the request is marked urgent and the scheduler must give the bus up.

The block also runs self-refresh. The scheduler can ask for it only while nothing is owed. The block then closes all banks, waits out the precharge period and drops the clock enable, which stays low until an exit request arrives. On exit the clock enable rises and the block waits the non-read recovery time before it issues one full AUTO REFRESH. A separate read-permit output stays low for a longer count of clock cycles after exit, so that READ commands wait their own recovery time.

All timing values are parameters given in clock cycles. The defaults assume a 5 ns clock: a 7.8 µs interval, 72 ns refresh time, 18 ns precharge time, 75 ns non-read exit wait and 200 cycles before a READ. A limit of eight postponed refreshes keeps the spacing between two refreshes below 70.3 µs.

Top module: `refresh_sequencer`

## Requirements
- R1: After reset, `cke` is high, `cmdKind` is 0, `busReq`, `urgent` and `busy` are low, and `readOk` is high.
- R2: Outside self-refresh, one refresh becomes owed every `REFI_CYCLES` clock cycles. `busReq` is high exactly while at least one refresh is owed.
- R3: `urgent` is high while the backlog equals `MAX_OWED`. Further interval expiries do not raise the backlog above `MAX_OWED`.
- R4: When `grant` is seen in an idle cycle with a backlog, the next cycle carries a precharge-all (`cmdKind` = 1). The first AUTO REFRESH (`cmdKind` = 2) follows exactly `RP_CYCLES` cycles after it.
- R5: While `grant` stays high, AUTO REFRESH commands follow each other exactly `RFC_CYCLES` cycles apart until the backlog is zero. The number issued equals the backlog, and a single precharge-all opens the batch.
- R6: `busy` is high from the precharge-all cycle until `RFC_CYCLES` cycles after the last AUTO REFRESH. `cmdKind` is 0 in every cycle where `busy` is low.
- R7: `srEnterReq` has no effect while a refresh is owed: `cke` stays high and no command is issued.
- R8: A self-refresh request accepted with no backlog issues a precharge-all and lowers `cke` exactly `RP_CYCLES` cycles later. While `cke` is low, no command is issued and no backlog builds up.
- R9: On `srExitReq`, `cke` rises in the next cycle. One AUTO REFRESH follows exactly `XSNR_CYCLES` cycles after the rise, and `busy` falls `RFC_CYCLES` cycles after that refresh.
- R10: `readOk` is low from the `cke` rise at self-refresh exit for exactly `XSRD_CYCLES` cycles, then high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| grant | input | 1 | Scheduler hands the command bus to the block |
| srEnterReq | input | 1 | Request to enter self-refresh (level) |
| srExitReq | input | 1 | Request to leave self-refresh |
| busReq | output | 1 | At least one refresh is owed |
| urgent | output | 1 | Backlog at its limit; pre-empt normal traffic |
| cmdKind | output | 2 | 0 none, 1 precharge-all, 2 AUTO REFRESH |
| cke | output | 1 | Requested clock-enable level |
| busy | output | 1 | Scheduler must hold off its own commands |
| readOk | output | 1 | READ commands are permitted |

## Verification
The bench walks a table of backlog depths: one, three and seven intervals, exactly eight, and eleven. Shallow depths show that the refresh count follows the backlog. Eight shows the point where `urgent` rises, and eleven shows that the backlog saturates rather than wraps. Each batch measures the precharge-to-refresh gap and the total batch length, which separates an off-by-one in either wait. Directed runs then hold a self-refresh request against a pending backlog and go through a full entry and exit. Those runs tell the non-read wait apart from the read wait, because the two counts differ by an order of magnitude.

// File: rtl/refsq_pkg.sv
package refsq_pkg;

  typedef enum logic [1:0] {
    CMD_NONE    = 2'd0,
    CMD_PREALL  = 2'd1,
    CMD_AUTOREF = 2'd2
  } cmdKind_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PRE,
    ST_RP,
    ST_REF,
    ST_RFC,
    ST_SRPRE,
    ST_SRRP,
    ST_SELF,
    ST_XS
  } seqState_e;

  // Strobes from the control FSM into the counter datapath
  typedef struct packed {
    logic owedDec;
    logic loadRp;
    logic loadRfc;
    logic loadXs;
    logic intervalHold;
    logic xsrdArm;
  } ctrlStrobes_t;

endpackage

// File: rtl/refsq_dp.sv
module refsq_dp
  import refsq_pkg::*;
#(
  parameter int REFI_CYCLES = 1560,
  parameter int RFC_CYCLES  = 15,
  parameter int RP_CYCLES   = 4,
  parameter int XSNR_CYCLES = 15,
  parameter int XSRD_CYCLES = 200,
  parameter int MAX_OWED    = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  ctrlStrobes_t stb,
  output logic         owedAny,
  output logic         owedFull,
  output logic         waitDone,
  output logic         readOk
);

  localparam int REFI_W   = $clog2(REFI_CYCLES);
  localparam int OWED_W   = $clog2(MAX_OWED + 1);
  localparam int WAIT_MAX = (RFC_CYCLES > RP_CYCLES)
                            ? ((RFC_CYCLES > XSNR_CYCLES) ? RFC_CYCLES : XSNR_CYCLES)
                            : ((RP_CYCLES > XSNR_CYCLES) ? RP_CYCLES : XSNR_CYCLES);
  localparam int WAIT_W   = $clog2(WAIT_MAX + 1);
  localparam int XSRD_W   = $clog2(XSRD_CYCLES + 1);

  localparam logic [REFI_W-1:0] REFI_LAST = REFI_W'(REFI_CYCLES - 1);
  localparam logic [OWED_W-1:0] OWED_TOP  = OWED_W'(MAX_OWED);
  // Loaded value is two below the spacing: one cycle for the issuing
  // state, one for the state change after the count reaches zero.
  localparam logic [WAIT_W-1:0] RP_LOAD   = WAIT_W'(RP_CYCLES - 2);
  localparam logic [WAIT_W-1:0] RFC_LOAD  = WAIT_W'(RFC_CYCLES - 2);
  // Exit wait starts one cycle before the clock enable rises.
  localparam logic [WAIT_W-1:0] XS_LOAD   = WAIT_W'(XSNR_CYCLES - 1);
  localparam logic [XSRD_W-1:0] XSRD_LOAD = XSRD_W'(XSRD_CYCLES);

  logic [REFI_W-1:0] intervalCnt;
  logic [OWED_W-1:0] owedCnt;
  logic [WAIT_W-1:0] waitCnt;
  logic [XSRD_W-1:0] xsrdCnt;
  logic              intervalTick;

  assign intervalTick = !stb.intervalHold && (intervalCnt == REFI_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intervalCnt <= '0;
    end else if (stb.intervalHold || intervalTick) begin
      intervalCnt <= '0;
    end else begin
      intervalCnt <= intervalCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      owedCnt <= '0;
    end else begin
      unique case ({intervalTick, stb.owedDec})
        2'b10:   if (owedCnt != OWED_TOP) owedCnt <= owedCnt + 1'b1;
        2'b01:   if (owedCnt != '0)       owedCnt <= owedCnt - 1'b1;
        default: owedCnt <= owedCnt;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      waitCnt <= '0;
    end else if (stb.loadRp) begin
      waitCnt <= RP_LOAD;
    end else if (stb.loadRfc) begin
      waitCnt <= RFC_LOAD;
    end else if (stb.loadXs) begin
      waitCnt <= XS_LOAD;
    end else if (waitCnt != '0) begin
      waitCnt <= waitCnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      xsrdCnt <= '0;
    end else if (stb.xsrdArm) begin
      xsrdCnt <= XSRD_LOAD;
    end else if (xsrdCnt != '0) begin
      xsrdCnt <= xsrdCnt - 1'b1;
    end
  end

  assign owedAny  = (owedCnt != '0);
  assign owedFull = (owedCnt == OWED_TOP);
  assign waitDone = (waitCnt == '0);
  assign readOk   = (xsrdCnt == '0);

endmodule

// File: rtl/refsq_ctrl.sv
module refsq_ctrl
  import refsq_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         grant,
  input  logic         srEnterReq,
  input  logic         srExitReq,
  input  logic         owedAny,
  input  logic         waitDone,
  output ctrlStrobes_t stb,
  output logic [1:0]   cmdKind,
  output logic         cke,
  output logic         busy
);

  seqState_e state, stateNext;
  logic      srAccept;

  assign srAccept = (state == ST_IDLE) && !(owedAny && grant) && srEnterReq && !owedAny;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    stb       = '0;
    unique case (state)
      ST_IDLE: begin
        if (owedAny && grant) stateNext = ST_PRE;
        else if (srAccept)    stateNext = ST_SRPRE;
      end
      ST_PRE: begin
        stb.loadRp = 1'b1;
        stateNext  = ST_RP;
      end
      ST_RP: begin
        if (waitDone) stateNext = ST_REF;
      end
      ST_REF: begin
        stb.owedDec = 1'b1;
        stb.loadRfc = 1'b1;
        stateNext   = ST_RFC;
      end
      ST_RFC: begin
        if (waitDone) stateNext = (owedAny && grant) ? ST_REF : ST_IDLE;
      end
      ST_SRPRE: begin
        stb.loadRp = 1'b1;
        stateNext  = ST_SRRP;
      end
      ST_SRRP: begin
        if (waitDone) stateNext = ST_SELF;
      end
      ST_SELF: begin
        stb.xsrdArm = 1'b1;
        if (srExitReq) begin
          stb.loadXs = 1'b1;
          stateNext  = ST_XS;
        end
      end
      ST_XS: begin
        if (waitDone) stateNext = ST_REF;
      end
      default: stateNext = ST_IDLE;
    endcase
    stb.intervalHold = srAccept || (state == ST_SRPRE) || (state == ST_SRRP)
                       || (state == ST_SELF) || (state == ST_XS);
  end

  always_comb begin
    unique case (state)
      ST_PRE, ST_SRPRE: cmdKind = CMD_PREALL;
      ST_REF:           cmdKind = CMD_AUTOREF;
      default:          cmdKind = CMD_NONE;
    endcase
  end

  assign cke  = (state != ST_SELF);
  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/refresh_sequencer.sv
module refresh_sequencer
  import refsq_pkg::*;
#(
  parameter int REFI_CYCLES = 1560,
  parameter int RFC_CYCLES  = 15,
  parameter int RP_CYCLES   = 4,
  parameter int XSNR_CYCLES = 15,
  parameter int XSRD_CYCLES = 200,
  parameter int MAX_OWED    = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       grant,
  input  logic       srEnterReq,
  input  logic       srExitReq,
  output logic       busReq,
  output logic       urgent,
  output logic [1:0] cmdKind,
  output logic       cke,
  output logic       busy,
  output logic       readOk
);

  ctrlStrobes_t stb;
  logic owedAny, owedFull, waitDone;

  refsq_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .grant     (grant),
    .srEnterReq(srEnterReq),
    .srExitReq (srExitReq),
    .owedAny   (owedAny),
    .waitDone  (waitDone),
    .stb       (stb),
    .cmdKind   (cmdKind),
    .cke       (cke),
    .busy      (busy)
  );

  refsq_dp #(
    .REFI_CYCLES(REFI_CYCLES),
    .RFC_CYCLES (RFC_CYCLES),
    .RP_CYCLES  (RP_CYCLES),
    .XSNR_CYCLES(XSNR_CYCLES),
    .XSRD_CYCLES(XSRD_CYCLES),
    .MAX_OWED   (MAX_OWED)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .owedAny (owedAny),
    .owedFull(owedFull),
    .waitDone(waitDone),
    .readOk  (readOk)
  );

  assign busReq = owedAny;
  assign urgent = owedFull;

endmodule

// File: rtl/refsq_checker.sv
module refsq_checker (
  input logic       clk,
  input logic       rstN,
  input logic       grant,
  input logic       srEnterReq,
  input logic       busReq,
  input logic       urgent,
  input logic [1:0] cmdKind,
  input logic       cke,
  input logic       busy,
  input logic       readOk
);

  p_urgent_has_req_r3: assert property (@(posedge clk) disable iff (!rstN)
    urgent |-> busReq);

  p_grant_opens_precharge_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && busReq && grant) |=> (cmdKind == 2'd1));

  p_refresh_spacing_r5: assert property (@(posedge clk) disable iff (!rstN)
    (cmdKind == 2'd2) |=> (cmdKind == 2'd0));

  p_cmd_only_busy_r6: assert property (@(posedge clk) disable iff (!rstN)
    (cmdKind != 2'd0) |-> busy);

  p_sr_blocked_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && busReq && srEnterReq && !grant) |=> (cke && cmdKind == 2'd0));

  p_quiet_self_refresh_r8: assert property (@(posedge clk) disable iff (!rstN)
    !cke |-> (cmdKind == 2'd0 && !busReq && busy));

  p_read_blocked_exit_r10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cke) |-> !readOk);

endmodule

bind refresh_sequencer refsq_checker u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .grant     (grant),
  .srEnterReq(srEnterReq),
  .busReq    (busReq),
  .urgent    (urgent),
  .cmdKind   (cmdKind),
  .cke       (cke),
  .busy      (busy),
  .readOk    (readOk)
);

// File: tb/refresh_sequencer_test.sv
`timescale 1ns/100ps
module refresh_sequencer_test;

  localparam int REFI = 200;
  localparam int RFC  = 15;
  localparam int RP   = 4;
  localparam int XSNR = 15;
  localparam int XSRD = 200;
  localparam int MAXO = 8;

  // Stimulus table: intervals waited, refreshes expected, urgent expected
  localparam int VEC_N = 5;
  localparam int VEC_INTERVALS [VEC_N] = '{1, 3, 7, 8, 11};
  localparam int VEC_REFS      [VEC_N] = '{1, 3, 7, 8, 8};
  localparam int VEC_URGENT    [VEC_N] = '{0, 0, 0, 1, 1};

  logic clk = 1'b0, rstN = 1'b0, grant = 1'b0, srEnterReq = 1'b0, srExitReq = 1'b0;
  logic busReq, urgent, cke, busy, readOk;
  logic [1:0] cmdKind;

  int total = 0;
  int bad   = 0;

  refresh_sequencer #(
    .REFI_CYCLES(REFI), .RFC_CYCLES(RFC), .RP_CYCLES(RP),
    .XSNR_CYCLES(XSNR), .XSRD_CYCLES(XSRD), .MAX_OWED(MAXO)
  ) uut (
    .clk(clk), .rstN(rstN), .grant(grant), .srEnterReq(srEnterReq),
    .srExitReq(srExitReq), .busReq(busReq), .urgent(urgent),
    .cmdKind(cmdKind), .cke(cke), .busy(busy), .readOk(readOk)
  );

  always #2.5 clk = ~clk;

  // Event monitor, sampled on the falling edge
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int preCnt = 0, refCnt = 0, lastPreCyc = 0, lastRefCyc = 0, preRefGap = 0;
  int tooClose = 0, busyFallCyc = 0, ckeFallCyc = 0, ckeRiseCyc = 0;
  int ckeFallCnt = 0, readOkRiseCyc = 0, quietBad = 0;
  logic prevBusy = 1'b0, prevCke = 1'b1, prevReadOk = 1'b1;

  always @(negedge clk) begin
    if (rstN) begin
      if (cmdKind == 2'd1) begin
        preCnt++;
        lastPreCyc = cyc;
      end
      if (cmdKind == 2'd2) begin
        if (lastRefCyc < lastPreCyc) preRefGap = cyc - lastPreCyc;
        if (refCnt > 0 && (cyc - lastRefCyc) < RFC) tooClose++;
        refCnt++;
        lastRefCyc = cyc;
      end
      if (prevBusy && !busy) busyFallCyc = cyc;
      if (prevCke && !cke) begin ckeFallCyc = cyc; ckeFallCnt++; end
      if (!prevCke && cke) ckeRiseCyc = cyc;
      if (!prevReadOk && readOk) readOkRiseCyc = cyc;
      if (!cke && cmdKind != 2'd0) quietBad++;
    end
    prevBusy   = busy;
    prevCke    = cke;
    prevReadOk = readOk;
  end

  task automatic check(string req, string what, int actual, int expected);
    total++;
    if (actual != expected) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, actual, expected);
    end
  endtask

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic doReset();
    rstN = 1'b0; grant = 1'b0; srEnterReq = 1'b0; srExitReq = 1'b0;
    cycles(3);
    rstN = 1'b1;
  endtask

  task automatic runBatch(output int ok);
    int guard = 0;
    ok = 1;
    grant = 1'b1;
    while (!busy && guard < 100) begin cycles(1); guard++; end
    while (busy && guard < 3000) begin cycles(1); guard++; end
    if (guard >= 3000 || guard < 2) ok = 0;
    grant = 1'b0;
  endtask

  initial begin
    int ok, refBase, preBase, closeBase, fallBase, quietBase;

    doReset();
    // R1: reset state
    check("R1", "cke", int'(cke), 1);
    check("R1", "cmdKind", int'(cmdKind), 0);
    check("R1", "busReq", int'(busReq), 0);
    check("R1", "urgent", int'(urgent), 0);
    check("R1", "busy", int'(busy), 0);
    check("R1", "readOk", int'(readOk), 1);

    // R2: request appears only once an interval has elapsed
    cycles(REFI - 10);
    check("R2", "busReq before first interval", int'(busReq), 0);
    cycles(20);
    check("R2", "busReq after first interval", int'(busReq), 1);

    // Table walk: backlog depth against batch contents
    for (int v = 0; v < VEC_N; v++) begin
      doReset();
      cycles(VEC_INTERVALS[v] * REFI + 10);
      check("R2", "busReq with backlog", int'(busReq), 1);
      check("R3", "urgent", int'(urgent), VEC_URGENT[v]);
      refBase = refCnt; preBase = preCnt; closeBase = tooClose;
      runBatch(ok);
      check("R5", "batch completed", ok, 1);
      check("R5", "refresh count", refCnt - refBase, VEC_REFS[v]);
      check("R5", "refresh spacing too short", tooClose - closeBase, 0);
      check("R4", "precharge count", preCnt - preBase, 1);
      check("R4", "precharge to refresh gap", preRefGap, RP);
      check("R6", "batch length", busyFallCyc - lastPreCyc, RP + VEC_REFS[v] * RFC);
      check("R5", "busReq after batch", int'(busReq), 0);
      check("R6", "idle command", int'(cmdKind), 0);
    end

    // R7: self-refresh request while a refresh is owed
    doReset();
    cycles(REFI + 10);
    fallBase = ckeFallCnt; preBase = preCnt;
    srEnterReq = 1'b1;
    cycles(30);
    check("R7", "cke held high", int'(cke), 1);
    check("R7", "cke falls", ckeFallCnt - fallBase, 0);
    check("R7", "commands issued", preCnt - preBase, 0);
    srEnterReq = 1'b0;

    // R8..R10: full self-refresh entry and exit
    doReset();
    cycles(10);
    preBase = preCnt;
    srEnterReq = 1'b1;
    cycles(1);
    srEnterReq = 1'b0;
    cycles(20);
    check("R8", "cke low", int'(cke), 0);
    check("R8", "entry precharge", preCnt - preBase, 1);
    check("R8", "precharge to cke fall", ckeFallCyc - lastPreCyc, RP);
    quietBase = quietBad;
    cycles(3 * REFI);
    check("R8", "cke still low", int'(cke), 0);
    check("R8", "no backlog in self-refresh", int'(busReq), 0);
    check("R8", "commands while cke low", quietBad - quietBase, 0);
    refBase = refCnt;
    srExitReq = 1'b1;
    cycles(1);
    srExitReq = 1'b0;
    check("R9", "cke after exit", int'(cke), 1);
    begin
      int guard = 0;
      while (busy && guard < 500) begin cycles(1); guard++; end
    end
    check("R9", "exit refresh count", refCnt - refBase, 1);
    check("R9", "cke rise to refresh", lastRefCyc - ckeRiseCyc, XSNR);
    check("R9", "refresh to busy fall", busyFallCyc - lastRefCyc, RFC);
    check("R10", "readOk still low", int'(readOk), 0);
    cycles(XSRD);
    check("R10", "readOk high", int'(readOk), 1);
    check("R10", "cke rise to readOk", readOkRiseCyc - ckeRiseCyc, XSRD);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog R1-to-R10 run actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule